// File: doc/BRIEF.md
# Edge-Triggered Counter Capture Channel

This block is a single timer channel working as an input-capture unit. An asynchronous signal from a pin is brought into the system-clock domain and watched for edges. When an edge of the kind chosen by software arrives, the block stores the value of an external free-running counter, raises an event flag and, if enabled, an interrupt. Software then reads the stored value as two bytes.

The two bytes of the stored value are kept consistent even if a new capture lands between the two byte reads, and either byte may be read first. A debug-freeze input keeps the capture path running but makes it record the counter value from just before the freeze began. The event flag is cleared by a read-then-write handshake on the control register.

Top module: `capture_channel`

## Requirements
- R1: After reset the control byte, both value bytes and the interrupt output all read as zero.
- R2: A pin transition is seen through a two-flop synchronizer and one edge register, so the event flag is first visible after the third rising clock edge that samples the new pin level, and not after the second.
- R3: Control bits [1:0] choose the active edge: 00 no capture, 01 rising only, 10 falling only, 11 both.
- R4: On a selected edge, the counter input present at the clock edge that sets the flag is stored, and the flag (control bit 7) becomes 1 at that same edge.
- R5: The interrupt output is 1 exactly when the flag is 1 and control bit 6 (interrupt enable) is 1.
- R6: The flag clears only on a control write with bit 7 equal to 0 that follows a control read that returned the flag as 1; a control write without that prior read leaves it set.
- R7: If a capture happens in the same cycle as a clearing write, the flag stays 1.
- R8: Address 1 reads the high byte and address 2 the low byte; reading the high byte first and the low byte next returns the two halves of one stored value.
- R9: Reading the low byte first and the high byte next also returns the two halves of one stored value.
- R10: A capture arriving between the first and second byte read of a pair does not change the byte returned by the second read.
- R11: Any write to the control register (address 0) drops a pending byte pair, so the next value read returns the live stored value.
- R12: Writes to addresses 1 and 2 have no effect on the stored value.
- R13: While the freeze input is 1, captures still occur and set the flag, and they store the counter value seen at the last clock edge before freeze went high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pin_i | input | 1 | Asynchronous channel input |
| count_i | input | CNT_W | Free-running counter value |
| freeze_i | input | 1 | Debug freeze: capture the held counter value |
| bus_addr_i | input | 2 | Register address: 0 control, 1 value high, 2 value low |
| bus_rd_i | input | 1 | Read strobe for the addressed register |
| bus_wr_i | input | 1 | Write strobe for the addressed register |
| bus_wdata_i | input | CNT_W/2 | Write data |
| bus_rdata_o | output | CNT_W/2 | Read data for the addressed register, combinational |
| irq_o | output | 1 | Channel interrupt |

## Verification
Two functions can meet in one cycle: a capture arriving from the edge pipeline and a software write to the control register that would clear the flag or drop the pending byte pair. The bench provokes this by timing a pin transition so that the third clock edge after it coincides with the clearing write, and separately by placing a capture between the two halves of a byte-pair read. A cycle-level reference model built from the requirements predicts every read and the interrupt, so the outcome of each collision (flag held, buffered byte unchanged, live byte after a control write) is judged against the model and against explicit expected bytes.

// File: rtl/capchan_pkg.sv
package capchan_pkg;

    typedef enum logic [1:0] {
        EDGE_OFF  = 2'b00,
        EDGE_RISE = 2'b01,
        EDGE_FALL = 2'b10,
        EDGE_BOTH = 2'b11
    } edge_mode_e;

    typedef enum logic [1:0] {
        REG_CTRL   = 2'd0,
        REG_VAL_HI = 2'd1,
        REG_VAL_LO = 2'd2,
        REG_NONE   = 2'd3
    } reg_addr_e;

    localparam int FLAG_BIT = 7;
    localparam int IE_BIT   = 6;

endpackage

// File: rtl/capchan_sync_edge.sv
module capchan_sync_edge #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pin_i,
    output logic rise_o,
    output logic fall_o
);

    typedef struct packed {
        logic [STAGES-1:0] chain;
        logic              last;
    } sync_t;

    sync_t s_d, s_q;

    always_comb begin
        s_d = s_q;
        s_d.chain[0] = pin_i;
        for (int i = 1; i < STAGES; i++) begin
            s_d.chain[i] = s_q.chain[i-1];
        end
        s_d.last = s_q.chain[STAGES-1];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign rise_o =  s_q.chain[STAGES-1] & ~s_q.last;
    assign fall_o = ~s_q.chain[STAGES-1] &  s_q.last;

    // R2
    rise_latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rise_o |-> $past(pin_i, STAGES));

    // R2
    fall_latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fall_o |-> !$past(pin_i, STAGES));

endmodule

// File: rtl/capchan_status.sv
module capchan_status
    import capchan_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       hit_i,
    input  logic       ctrl_rd_i,
    input  logic       ctrl_wr_i,
    input  logic       wr_flag_i,
    input  logic       wr_ie_i,
    input  logic [1:0] wr_mode_i,
    output logic       flag_o,
    output logic       ie_o,
    output logic [1:0] mode_o,
    output logic       irq_o
);

    typedef struct packed {
        logic       flag;
        logic       armed;
        logic       ie;
        edge_mode_e mode;
    } status_t;

    status_t st_d, st_q;
    logic    clear;

    always_comb begin
        st_d  = st_q;
        clear = st_q.armed & ctrl_wr_i & ~wr_flag_i;
        st_d.flag = hit_i | (st_q.flag & ~clear);
        if (ctrl_rd_i && st_q.flag) begin
            st_d.armed = 1'b1;
        end
        if (ctrl_wr_i) begin
            st_d.armed = 1'b0;
            st_d.ie    = wr_ie_i;
            st_d.mode  = edge_mode_e'(wr_mode_i);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '{flag: 1'b0, armed: 1'b0, ie: 1'b0, mode: EDGE_OFF};
        end else begin
            st_q <= st_d;
        end
    end

    assign flag_o = st_q.flag;
    assign ie_o   = st_q.ie;
    assign mode_o = st_q.mode;
    assign irq_o  = st_q.flag & st_q.ie;

    // R7
    set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        hit_i |=> st_q.flag);

    // R6
    clear_handshake_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(st_q.flag) |-> $past(ctrl_wr_i && st_q.armed && !wr_flag_i));

endmodule

// File: rtl/capchan_capture.sv
module capchan_capture #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             hit_i,
    input  logic             freeze_i,
    input  logic [CNT_W-1:0] count_i,
    output logic [CNT_W-1:0] cap_o
);

    typedef struct packed {
        logic [CNT_W-1:0] cap;
        logic [CNT_W-1:0] hold;
    } capture_t;

    capture_t c_d, c_q;

    always_comb begin
        c_d = c_q;
        if (!freeze_i) begin
            c_d.hold = count_i;
        end
        if (hit_i) begin
            c_d.cap = freeze_i ? c_q.hold : count_i;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            c_q <= '0;
        end else begin
            c_q <= c_d;
        end
    end

    assign cap_o = c_q.cap;

    // R4
    cap_only_on_hit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !hit_i |=> $stable(c_q.cap));

    // R13
    frozen_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (freeze_i && $past(freeze_i) && hit_i) |=> (c_q.cap == $past(c_q.hold, 2)));

endmodule

// File: rtl/capchan_readbuf.sv
module capchan_readbuf #(
    parameter int DATA_W = 8
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [2*DATA_W-1:0] cap_i,
    input  logic                rd_hi_i,
    input  logic                rd_lo_i,
    input  logic                drop_i,
    output logic [DATA_W-1:0]   hi_o,
    output logic [DATA_W-1:0]   lo_o
);

    typedef struct packed {
        logic              valid;
        logic              holds_hi;
        logic [DATA_W-1:0] held;
    } rbuf_t;

    rbuf_t rb_d, rb_q;
    logic [DATA_W-1:0] live_hi, live_lo;

    assign live_hi = cap_i[2*DATA_W-1:DATA_W];
    assign live_lo = cap_i[DATA_W-1:0];

    always_comb begin
        rb_d = rb_q;
        if (rd_hi_i) begin
            if (rb_q.valid && rb_q.holds_hi) begin
                rb_d.valid = 1'b0;
            end else begin
                rb_d.valid    = 1'b1;
                rb_d.holds_hi = 1'b0;
                rb_d.held     = live_lo;
            end
        end
        if (rd_lo_i) begin
            if (rb_q.valid && !rb_q.holds_hi) begin
                rb_d.valid = 1'b0;
            end else begin
                rb_d.valid    = 1'b1;
                rb_d.holds_hi = 1'b1;
                rb_d.held     = live_hi;
            end
        end
        if (drop_i) begin
            rb_d.valid = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rb_q <= '0;
        end else begin
            rb_q <= rb_d;
        end
    end

    assign hi_o = (rb_q.valid &&  rb_q.holds_hi) ? rb_q.held : live_hi;
    assign lo_o = (rb_q.valid && !rb_q.holds_hi) ? rb_q.held : live_lo;

    // R10
    held_byte_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rb_q.valid && !rd_hi_i && !rd_lo_i && !drop_i) |=> (rb_q.valid && $stable(rb_q.held)));

    // R11
    drop_pair_chk: assert property (@(posedge clk) disable iff (!rst_n)
        drop_i |=> !rb_q.valid);

endmodule

// File: rtl/capture_channel.sv
module capture_channel
    import capchan_pkg::*;
#(
    parameter int CNT_W       = 16,
    parameter int SYNC_STAGES = 2
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 pin_i,
    input  logic [CNT_W-1:0]     count_i,
    input  logic                 freeze_i,
    input  logic [1:0]           bus_addr_i,
    input  logic                 bus_rd_i,
    input  logic                 bus_wr_i,
    input  logic [CNT_W/2-1:0]   bus_wdata_i,
    output logic [CNT_W/2-1:0]   bus_rdata_o,
    output logic                 irq_o
);

    localparam int DATA_W = CNT_W / 2;

    logic              rise, fall, hit;
    logic              flag, ie;
    logic [1:0]        mode;
    logic              sel_ctrl, sel_hi, sel_lo;
    logic              ctrl_wr;
    logic [CNT_W-1:0]  cap;
    logic [DATA_W-1:0] view_hi, view_lo;
    logic              wdata_unused;

    assign sel_ctrl     = (bus_addr_i == REG_CTRL);
    assign sel_hi       = (bus_addr_i == REG_VAL_HI);
    assign sel_lo       = (bus_addr_i == REG_VAL_LO);
    assign ctrl_wr      = bus_wr_i & sel_ctrl;
    assign wdata_unused = ^bus_wdata_i[IE_BIT-1:2];

    capchan_sync_edge #(
        .STAGES (SYNC_STAGES)
    ) u_sync (
        .clk    (clk),
        .rst_n  (rst_n),
        .pin_i  (pin_i),
        .rise_o (rise),
        .fall_o (fall)
    );

    assign hit = (mode[0] & rise) | (mode[1] & fall);

    capchan_status u_status (
        .clk       (clk),
        .rst_n     (rst_n),
        .hit_i     (hit),
        .ctrl_rd_i (bus_rd_i & sel_ctrl),
        .ctrl_wr_i (ctrl_wr),
        .wr_flag_i (bus_wdata_i[FLAG_BIT]),
        .wr_ie_i   (bus_wdata_i[IE_BIT]),
        .wr_mode_i (bus_wdata_i[1:0]),
        .flag_o    (flag),
        .ie_o      (ie),
        .mode_o    (mode),
        .irq_o     (irq_o)
    );

    capchan_capture #(
        .CNT_W (CNT_W)
    ) u_capture (
        .clk      (clk),
        .rst_n    (rst_n),
        .hit_i    (hit),
        .freeze_i (freeze_i),
        .count_i  (count_i),
        .cap_o    (cap)
    );

    capchan_readbuf #(
        .DATA_W (DATA_W)
    ) u_readbuf (
        .clk     (clk),
        .rst_n   (rst_n),
        .cap_i   (cap),
        .rd_hi_i (bus_rd_i & sel_hi),
        .rd_lo_i (bus_rd_i & sel_lo),
        .drop_i  (ctrl_wr),
        .hi_o    (view_hi),
        .lo_o    (view_lo)
    );

    always_comb begin
        bus_rdata_o = '0;
        case (bus_addr_i)
            REG_CTRL: begin
                bus_rdata_o[FLAG_BIT] = flag;
                bus_rdata_o[IE_BIT]   = ie;
                bus_rdata_o[1:0]      = mode;
            end
            REG_VAL_HI: bus_rdata_o = view_hi;
            REG_VAL_LO: bus_rdata_o = view_lo;
            default:    bus_rdata_o = '0;
        endcase
    end

    // R12
    value_write_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr_i && !sel_ctrl && !hit) |=> $stable(cap));

    // R5
    irq_follows_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq_o) |-> (flag && ie));

endmodule

// File: tb/capture_channel_test.sv
`timescale 1ns/100ps
module capture_channel_test;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        pin_i;
    logic [15:0] count_i;
    logic        freeze_i;
    logic [1:0]  bus_addr_i;
    logic        bus_rd_i;
    logic        bus_wr_i;
    logic [7:0]  bus_wdata_i;
    logic [7:0]  bus_rdata_o;
    logic        irq_o;

    always #2.5 clk = ~clk;

    capture_channel uut (
        .clk         (clk),
        .rst_n       (rst_n),
        .pin_i       (pin_i),
        .count_i     (count_i),
        .freeze_i    (freeze_i),
        .bus_addr_i  (bus_addr_i),
        .bus_rd_i    (bus_rd_i),
        .bus_wr_i    (bus_wr_i),
        .bus_wdata_i (bus_wdata_i),
        .bus_rdata_o (bus_rdata_o),
        .irq_o       (irq_o)
    );

    int checks = 0;
    int errors = 0;
    bit done   = 0;

    logic        pin_v, frz_v;
    logic [15:0] cnt;
    logic [7:0]  last_rd;

    // reference model state
    logic        m_p1, m_p2, m_p3;
    logic        m_flag, m_armed, m_ie;
    logic [1:0]  m_mode;
    logic [15:0] m_cap, m_hold;
    logic        m_bv, m_bhi;
    logic [7:0]  m_bb;

    task automatic report();
        if (!done) begin
            done = 1;
            $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
        end
    endtask

    task automatic check8(input logic [7:0] act, input logic [7:0] exp, input string tag);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %02h expected %02h", tag, act, exp);
        end
    endtask

    function automatic logic [7:0] model_rdata(input logic [1:0] a);
        case (a)
            2'd0:    return {m_flag, m_ie, 4'b0000, m_mode};
            2'd1:    return (m_bv && m_bhi)  ? m_bb : m_cap[15:8];
            2'd2:    return (m_bv && !m_bhi) ? m_bb : m_cap[7:0];
            default: return 8'h00;
        endcase
    endfunction

    task automatic model_reset();
        {m_p1, m_p2, m_p3} = 3'b000;
        m_flag = 0; m_armed = 0; m_ie = 0; m_mode = 2'b00;
        m_cap = '0; m_hold = '0; m_bv = 0; m_bhi = 0; m_bb = '0;
    endtask

    task automatic model_tick(input logic rd, input logic wr, input logic [1:0] a, input logic [7:0] wd);
        logic rise, fall, hit, clr;
        logic n_armed, n_bv, n_bhi;
        logic [7:0] n_bb;
        rise = m_p2 & ~m_p3;
        fall = ~m_p2 & m_p3;
        hit  = (m_mode[0] & rise) | (m_mode[1] & fall);
        clr  = wr && (a == 2'd0) && m_armed && !wd[7];
        n_armed = m_armed;
        if (rd && a == 2'd0 && m_flag) n_armed = 1;
        n_bv = m_bv; n_bhi = m_bhi; n_bb = m_bb;
        if (rd && a == 2'd1) begin
            if (m_bv && m_bhi) n_bv = 0;
            else begin n_bv = 1; n_bhi = 0; n_bb = m_cap[7:0]; end
        end
        if (rd && a == 2'd2) begin
            if (m_bv && !m_bhi) n_bv = 0;
            else begin n_bv = 1; n_bhi = 1; n_bb = m_cap[15:8]; end
        end
        if (wr && a == 2'd0) begin
            n_armed = 0; n_bv = 0;
            m_ie = wd[6]; m_mode = wd[1:0];
        end
        if (hit) m_cap = frz_v ? m_hold : cnt;
        if (!frz_v) m_hold = cnt;
        m_flag = hit | (m_flag & ~clr);
        m_armed = n_armed; m_bv = n_bv; m_bhi = n_bhi; m_bb = n_bb;
        m_p3 = m_p2; m_p2 = m_p1; m_p1 = pin_v;
    endtask

    task automatic step(input logic rd, input logic wr, input logic [1:0] a,
                        input logic [7:0] wd, input string tag);
        pin_i = pin_v; freeze_i = frz_v; count_i = cnt;
        bus_rd_i = rd; bus_wr_i = wr; bus_addr_i = a; bus_wdata_i = wd;
        #1;
        if (rd) begin
            check8(bus_rdata_o, model_rdata(a), tag);
            last_rd = bus_rdata_o;
        end
        check8({7'd0, irq_o}, {7'd0, m_flag & m_ie}, "R5");
        model_tick(rd, wr, a, wd);
        @(posedge clk);
        @(negedge clk);
        bus_rd_i = 0; bus_wr_i = 0;
        cnt = cnt + 16'h0137;
    endtask

    task automatic idle(input int n, input string tag);
        for (int i = 0; i < n; i++) step(0, 0, 2'd0, 8'h00, tag);
    endtask

    initial begin
        #900000;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        report();
        $finish;
    end

    initial begin
        logic [15:0] cap_exp, frz_exp;
        logic [7:0]  lo_old;
        int hold_cnt;
        void'($urandom(32'd2024));
        pin_v = 0; frz_v = 0; cnt = 16'h1000; last_rd = '0;
        pin_i = 0; freeze_i = 0; count_i = cnt;
        bus_rd_i = 0; bus_wr_i = 0; bus_addr_i = 0; bus_wdata_i = 0;
        model_reset();
        rst_n = 0;
        repeat (4) @(posedge clk);
        @(negedge clk);
        rst_n = 1;

        // R1 reset state
        step(1, 0, 2'd0, 8'h00, "R1"); check8(last_rd, 8'h00, "R1");
        step(1, 0, 2'd1, 8'h00, "R1"); check8(last_rd, 8'h00, "R1");
        step(1, 0, 2'd2, 8'h00, "R1"); check8(last_rd, 8'h00, "R1");
        check8({7'd0, irq_o}, 8'h00, "R1");

        // R2 / R4 latency and captured value, rising mode with interrupt
        step(0, 1, 2'd0, 8'h41, "R3");
        idle(3, "R2");
        pin_v = 1;
        step(0, 0, 2'd0, 8'h00, "R2");
        step(0, 0, 2'd0, 8'h00, "R2");
        cap_exp = cnt;
        step(1, 0, 2'd0, 8'h00, "R2"); check8(last_rd, 8'h41, "R2");
        step(1, 0, 2'd0, 8'h00, "R2"); check8(last_rd, 8'hC1, "R4");
        check8({7'd0, irq_o}, 8'h01, "R5");
        step(1, 0, 2'd1, 8'h00, "R8"); check8(last_rd, cap_exp[15:8], "R8");
        step(1, 0, 2'd2, 8'h00, "R8"); check8(last_rd, cap_exp[7:0], "R8");

        // R6 clear after read
        step(0, 1, 2'd0, 8'h41, "R6");
        step(1, 0, 2'd0, 8'h00, "R6"); check8(last_rd, 8'h41, "R6");
        check8({7'd0, irq_o}, 8'h00, "R5");

        // R3 falling edge ignored in rising mode
        pin_v = 0; idle(4, "R3");
        step(1, 0, 2'd0, 8'h00, "R3"); check8(last_rd, 8'h41, "R3");
        pin_v = 1; idle(4, "R3");
        // R6 write without prior read leaves flag
        step(0, 1, 2'd0, 8'h43, "R6");
        step(1, 0, 2'd0, 8'h00, "R6"); check8(last_rd, 8'hC3, "R6");

        // R7 capture in same cycle as clearing write
        pin_v = 0;
        step(0, 0, 2'd0, 8'h00, "R7");
        step(0, 0, 2'd0, 8'h00, "R7");
        step(0, 1, 2'd0, 8'h43, "R7");
        step(1, 0, 2'd0, 8'h00, "R7"); check8(last_rd, 8'hC3, "R7");
        step(0, 1, 2'd0, 8'h03, "R6");
        step(1, 0, 2'd0, 8'h00, "R6"); check8(last_rd, 8'h03, "R6");

        // R3 mode 00 and mode 10
        step(0, 1, 2'd0, 8'h00, "R3");
        pin_v = 1; idle(4, "R3");
        pin_v = 0; idle(4, "R3");
        step(1, 0, 2'd0, 8'h00, "R3"); check8(last_rd, 8'h00, "R3");
        step(0, 1, 2'd0, 8'h02, "R3");
        pin_v = 1; idle(4, "R3");
        step(1, 0, 2'd0, 8'h00, "R3"); check8(last_rd, 8'h02, "R3");
        pin_v = 0; idle(4, "R3");
        step(1, 0, 2'd0, 8'h00, "R3"); check8(last_rd, 8'h82, "R3");

        // R12 writes to value addresses ignored
        cap_exp = m_cap;
        step(0, 1, 2'd1, 8'hAA, "R12");
        step(0, 1, 2'd2, 8'h55, "R12");
        step(1, 0, 2'd1, 8'h00, "R12"); check8(last_rd, cap_exp[15:8], "R12");
        step(1, 0, 2'd2, 8'h00, "R12"); check8(last_rd, cap_exp[7:0], "R12");

        // R9 low byte first
        step(1, 0, 2'd2, 8'h00, "R9"); lo_old = last_rd;
        step(1, 0, 2'd1, 8'h00, "R9"); check8(last_rd, cap_exp[15:8], "R9");

        // R10 capture between the two reads of a pair
        step(1, 0, 2'd1, 8'h00, "R10");
        pin_v = 1; idle(4, "R10");
        pin_v = 0; idle(4, "R10");
        step(1, 0, 2'd2, 8'h00, "R10"); check8(last_rd, lo_old, "R10");

        // R11 control write drops a pending pair
        step(1, 0, 2'd1, 8'h00, "R11");
        pin_v = 1; idle(2, "R11");
        pin_v = 0; idle(4, "R11");
        step(0, 1, 2'd0, 8'h02, "R11");
        step(1, 0, 2'd2, 8'h00, "R11"); check8(last_rd, m_cap[7:0], "R11");
        step(1, 0, 2'd1, 8'h00, "R11");

        // R13 freeze
        frz_exp = cnt;
        step(0, 0, 2'd0, 8'h00, "R13");
        frz_v = 1;
        pin_v = 1; idle(3, "R13");
        pin_v = 0; idle(4, "R13");
        step(1, 0, 2'd0, 8'h00, "R13"); check8(last_rd, 8'h82, "R13");
        step(1, 0, 2'd1, 8'h00, "R13"); check8(last_rd, frz_exp[15:8], "R13");
        step(1, 0, 2'd2, 8'h00, "R13"); check8(last_rd, frz_exp[7:0], "R13");
        frz_v = 0;

        // constrained random phase against the model
        hold_cnt = 0;
        for (int i = 0; i < 4000; i++) begin
            int r;
            logic [1:0] a;
            logic [7:0] wd;
            r = $urandom_range(0, 99);
            a = 2'($urandom_range(0, 2));
            wd = 8'($urandom);
            if (hold_cnt >= 2 && $urandom_range(0, 2) == 0) begin
                pin_v = ~pin_v; hold_cnt = 0;
            end else begin
                hold_cnt++;
            end
            if ($urandom_range(0, 59) == 0) frz_v = ~frz_v;
            if (r < 40) begin
                step(1, 0, a, 8'h00, (a == 2'd0) ? "R6" : ((a == 2'd1) ? "R8" : "R9"));
            end else if (r < 52) begin
                step(0, 1, 2'd0, {wd[7:6], 4'b0000, wd[1:0]}, "R11");
            end else if (r < 56) begin
                step(0, 1, (a == 2'd0) ? 2'd1 : a, wd, "R12");
            end else begin
                step(0, 0, 2'd0, 8'h00, "R4");
            end
        end

        report();
        $finish;
    end

endmodule